// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Breakpoint Arbitration

This block tracks the operating mode of a small processor core and moves it between its active clocks and its low-power states. The core sends a one-cycle sleep request with a 3-bit target code. A per-channel breakpoint match bus reports whether a breakpoint is armed on the fetch that follows the request. Depending on the target, an armed breakpoint either cancels the transition or is serviced after the transition completes. For the deepest states it produces no interrupt and only sets that channel's condition flag.

Moves from the sub-clock active mode back to a fast clock load a programmable settling count and wait for it to run out. Returns from standby and watch do the same. A wake-up input brings the block out of any low-power state and back to the active mode it left. The break-interrupt request is held until acknowledged. The per-channel flags are held until a write-one-to-clear pulse clears them.

Top module: `pwrModeSeq`

## Requirements
- R1: Reset puts the mode in high-speed (000), with the interrupt request low and all condition flags clear.
- R2: Mode codes are 000 high-speed, 001 medium-speed, 010 sub-active, 011 sleep, 100 subsleep, 101 standby and 110 watch. From high or medium the accepted targets are sleep, sub-active, standby and watch. From sub-active they are subsleep, high, medium, standby and watch. Any other code, including 111, leaves the mode and all outputs unchanged.
- R3: With no breakpoint match, an accepted sleep, subsleep, standby or watch request changes the mode at the accepting clock edge. It raises no interrupt and sets no flag.
- R4: A sleep request from high or medium, or a subsleep request from sub-active, with any match bit set keeps the current mode and raises the interrupt request at the accepting edge.
- R5: A sub-active request from high or medium changes the mode at the accepting edge. If a match bit was set, the interrupt request rises one edge later.
- R6: A high or medium request from sub-active loads the N-cycle settling count. The mode changes N+1 edges after the accepting edge. If a match bit was set, the interrupt request rises at edge N+2.
- R7: A standby or watch request enters that mode at the accepting edge and never raises the interrupt request. Each set match bit sets the condition flag of the same index (bit 0 is channel A, bit 1 is channel B).
- R8: The interrupt request stays high until an acknowledge pulse. Each condition flag stays set until a one is written to its bit of the clear input.
- R9: A wake-up in sleep or subsleep restores the previous active mode at the next edge. A wake-up in standby or watch loads the settling count N and restores the mode N+1 edges after the wake edge.
- R10: Sleep requests arriving while in a low-power state or while settling are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | One-cycle request to change mode |
| modeSel | input | 3 | Target mode code for the request |
| brkMatch | input | 2 | Breakpoint armed on the post-request fetch, one bit per channel |
| settleCount | input | 16 | Oscillator settling count loaded when settling starts |
| wakeUp | input | 1 | Wake event for low-power states |
| brkAck | input | 1 | Acknowledge of the break-interrupt request |
| flagClr | input | 2 | Write-one-to-clear for the condition flags |
| curMode | output | 3 | Current operating mode code |
| brkIrq | output | 1 | Break-interrupt request |
| condFlag | output | 2 | Per-channel condition-match flags |

## Verification
The assertions assume that the core gives `modeSel` and `brkMatch` valid values in the same cycle as `sleepReq`. They also assume that `sleepReq` is a single-cycle pulse. The bench drives each request for exactly one clock, with its code and match bits set up at the falling edge beforehand. It acknowledges and clears only between requests, never in the cycle where a raise could occur. This keeps the set-wins-over-clear ordering out of the checked windows.

// File: rtl/pwrModeSeqPkg.sv
package pwrModeSeqPkg;
  localparam logic [2:0] MODE_HIGH     = 3'd0;
  localparam logic [2:0] MODE_MEDIUM   = 3'd1;
  localparam logic [2:0] MODE_SUBACT   = 3'd2;
  localparam logic [2:0] MODE_SLEEP    = 3'd3;
  localparam logic [2:0] MODE_SUBSLEEP = 3'd4;
  localparam logic [2:0] MODE_STANDBY  = 3'd5;
  localparam logic [2:0] MODE_WATCH    = 3'd6;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_SETTLE,
    SEQ_LOW,
    SEQ_WAKE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterSel;    // curMode <= modeSel, remember old mode
    logic latchTarget; // hold modeSel for a settled transition
    logic loadCnt;     // load settling counter
    logic decCnt;      // count settling down
    logic enterTarget; // curMode <= held target
    logic restore;     // curMode <= remembered active mode
    logic raiseBrk;    // set break-interrupt request
    logic setFlags;    // OR match bits into condition flags
  } seqStrobe_t;
endpackage

// File: rtl/pwrModeSeqCtrl.sv
module pwrModeSeqCtrl
  import pwrModeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic [2:0] modeSel,
  input  logic       anyMatch,
  input  logic       wakeUp,
  input  logic [2:0] curMode,
  input  logic       cntZero,
  output seqStrobe_t stb,
  output logic       seqIdle
);
  seqState_t state, stateNxt;
  logic pendBrk, pendNxt;

  logic onFast, onSub, reqLight, reqDeep, reqToSub, reqToFast, inLight;

  always_comb begin
    onFast    = (curMode == MODE_HIGH) || (curMode == MODE_MEDIUM);
    onSub     = (curMode == MODE_SUBACT);
    reqLight  = (onFast && modeSel == MODE_SLEEP) || (onSub && modeSel == MODE_SUBSLEEP);
    reqDeep   = (onFast || onSub) && (modeSel == MODE_STANDBY || modeSel == MODE_WATCH);
    reqToSub  = onFast && (modeSel == MODE_SUBACT);
    reqToFast = onSub && (modeSel == MODE_HIGH || modeSel == MODE_MEDIUM);
    inLight   = (curMode == MODE_SLEEP) || (curMode == MODE_SUBSLEEP);
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    pendNxt  = pendBrk;
    unique case (state)
      SEQ_RUN: begin
        if (pendBrk) begin
          stb.raiseBrk = 1'b1;
          pendNxt      = 1'b0;
        end
        if (sleepReq) begin
          if (reqLight) begin
            if (anyMatch) begin
              stb.raiseBrk = 1'b1;
            end else begin
              stb.enterSel = 1'b1;
              stateNxt     = SEQ_LOW;
            end
          end else if (reqDeep) begin
            stb.enterSel = 1'b1;
            stb.setFlags = 1'b1;
            stateNxt     = SEQ_LOW;
          end else if (reqToSub) begin
            stb.enterSel = 1'b1;
            pendNxt      = anyMatch;
          end else if (reqToFast) begin
            stb.latchTarget = 1'b1;
            stb.loadCnt     = 1'b1;
            pendNxt         = anyMatch;
            stateNxt        = SEQ_SETTLE;
          end
        end
      end
      SEQ_SETTLE: begin
        if (cntZero) begin
          stb.enterTarget = 1'b1;
          stateNxt        = SEQ_RUN;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      SEQ_LOW: begin
        if (wakeUp) begin
          if (inLight) begin
            stb.restore = 1'b1;
            stateNxt    = SEQ_RUN;
          end else begin
            stb.loadCnt = 1'b1;
            stateNxt    = SEQ_WAKE;
          end
        end
      end
      SEQ_WAKE: begin
        if (cntZero) begin
          stb.restore = 1'b1;
          stateNxt    = SEQ_RUN;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      default: stateNxt = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_RUN;
      pendBrk <= 1'b0;
    end else begin
      state   <= stateNxt;
      pendBrk <= pendNxt;
    end
  end

  assign seqIdle = (state == SEQ_RUN);
endmodule

// File: rtl/pwrModeSeqDp.sv
module pwrModeSeqDp
  import pwrModeSeqPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [2:0]       modeSel,
  input  logic [NCH-1:0]   brkMatch,
  input  logic [CNT_W-1:0] settleCount,
  input  logic             brkAck,
  input  logic [NCH-1:0]   flagClr,
  output logic [2:0]       curMode,
  output logic             cntZero,
  output logic             brkIrq,
  output logic [NCH-1:0]   condFlag
);
  logic [CNT_W-1:0] settleCnt;
  logic [2:0]       savedMode, targetMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= MODE_HIGH;
      savedMode  <= MODE_HIGH;
      targetMode <= MODE_HIGH;
    end else begin
      if (stb.enterSel) begin
        curMode   <= modeSel;
        savedMode <= curMode;
      end else if (stb.enterTarget) begin
        curMode <= targetMode;
      end else if (stb.restore) begin
        curMode <= savedMode;
      end
      if (stb.latchTarget) targetMode <= modeSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            settleCnt <= '0;
    else if (stb.loadCnt) settleCnt <= settleCount;
    else if (stb.decCnt)  settleCnt <= settleCnt - 1'b1;
  end
  assign cntZero = (settleCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)             brkIrq <= 1'b0;
    else if (stb.raiseBrk) brkIrq <= 1'b1;
    else if (brkAck)       brkIrq <= 1'b0;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)                             condFlag[ch] <= 1'b0;
      else if (stb.setFlags && brkMatch[ch]) condFlag[ch] <= 1'b1;
      else if (flagClr[ch])                  condFlag[ch] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrModeSeq.sv
module pwrModeSeq
  import pwrModeSeqPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic [2:0]       modeSel,
  input  logic [NCH-1:0]   brkMatch,
  input  logic [CNT_W-1:0] settleCount,
  input  logic             wakeUp,
  input  logic             brkAck,
  input  logic [NCH-1:0]   flagClr,
  output logic [2:0]       curMode,
  output logic             brkIrq,
  output logic [NCH-1:0]   condFlag
);
  seqStrobe_t stb;
  logic cntZero, seqIdle;

  pwrModeSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .modeSel(modeSel),
    .anyMatch(|brkMatch), .wakeUp(wakeUp), .curMode(curMode),
    .cntZero(cntZero), .stb(stb), .seqIdle(seqIdle)
  );

  pwrModeSeqDp #(.CNT_W(CNT_W), .NCH(NCH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .modeSel(modeSel),
    .brkMatch(brkMatch), .settleCount(settleCount), .brkAck(brkAck),
    .flagClr(flagClr), .curMode(curMode), .cntZero(cntZero),
    .brkIrq(brkIrq), .condFlag(condFlag)
  );
endmodule

// File: rtl/pwrModeSeqChk.sv
module pwrModeSeqChk
  import pwrModeSeqPkg::*;
#(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           sleepReq,
  input logic [2:0]     modeSel,
  input logic [NCH-1:0] brkMatch,
  input logic           wakeUp,
  input logic           brkAck,
  input logic [2:0]     curMode,
  input logic           brkIrq,
  input logic [NCH-1:0] condFlag,
  input logic           seqIdle
);
  logic onFast, onSub, cancelReq, deepReq;
  assign onFast    = (curMode == MODE_HIGH) || (curMode == MODE_MEDIUM);
  assign onSub     = (curMode == MODE_SUBACT);
  assign cancelReq = sleepReq && seqIdle && (|brkMatch) &&
                     ((onFast && modeSel == MODE_SLEEP) || (onSub && modeSel == MODE_SUBSLEEP));
  assign deepReq   = sleepReq && seqIdle && (onFast || onSub) &&
                     (modeSel == MODE_STANDBY || modeSel == MODE_WATCH);

  assert_cancel_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    cancelReq |=> ($stable(curMode) && brkIrq));

  assert_deep_no_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    deepReq |=> (!$rose(brkIrq) && curMode == $past(modeSel)));

  assert_deep_flag_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    (deepReq && brkMatch[0]) |=> condFlag[0]);

  assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && seqIdle && modeSel == 3'd7) |=> $stable(curMode));

  assert_ack_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(brkIrq) |-> $past(brkAck));

  assert_irq_in_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkIrq) |-> (curMode == MODE_HIGH || curMode == MODE_MEDIUM || curMode == MODE_SUBACT));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!seqIdle && !wakeUp && (curMode == MODE_SLEEP || curMode == MODE_SUBSLEEP)) |=> $stable(curMode));
endmodule

bind pwrModeSeq pwrModeSeqChk #(.NCH(NCH)) uChk (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .modeSel(modeSel),
  .brkMatch(brkMatch), .wakeUp(wakeUp), .brkAck(brkAck), .curMode(curMode),
  .brkIrq(brkIrq), .condFlag(condFlag), .seqIdle(seqIdle)
);

// File: tb/tb_pwrModeSeq.sv
module tb_pwrModeSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepReq = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [1:0]  brkMatch = 2'b00;
  logic [15:0] settleCount = 16'd3;
  logic        wakeUp = 1'b0;
  logic        brkAck = 1'b0;
  logic [1:0]  flagClr = 2'b00;
  logic [2:0]  curMode;
  logic        brkIrq;
  logic [1:0]  condFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwrModeSeq dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .modeSel(modeSel),
    .brkMatch(brkMatch), .settleCount(settleCount), .wakeUp(wakeUp),
    .brkAck(brkAck), .flagClr(flagClr), .curMode(curMode),
    .brkIrq(brkIrq), .condFlag(condFlag)
  );

  // {sel, match, expMode, expIrq, expFlag, doWake, wakeMode}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {3'd3, 2'b00, 3'd3, 1'b0, 2'b00, 1'b1, 3'd0},
    {3'd3, 2'b01, 3'd0, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd2, 2'b10, 3'd2, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd4, 2'b01, 3'd2, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd4, 2'b00, 3'd4, 1'b0, 2'b00, 1'b1, 3'd2},
    {3'd7, 2'b11, 3'd2, 1'b0, 2'b00, 1'b0, 3'd0},
    {3'd3, 2'b01, 3'd2, 1'b0, 2'b00, 1'b0, 3'd0},
    {3'd6, 2'b01, 3'd6, 1'b0, 2'b01, 1'b1, 3'd2},
    {3'd0, 2'b01, 3'd0, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd1, 2'b11, 3'd0, 1'b0, 2'b00, 1'b0, 3'd0},
    {3'd5, 2'b10, 3'd5, 1'b0, 2'b10, 1'b1, 3'd0},
    {3'd2, 2'b00, 3'd2, 1'b0, 2'b00, 1'b0, 3'd0},
    {3'd1, 2'b11, 3'd1, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd3, 2'b10, 3'd1, 1'b1, 2'b00, 1'b0, 3'd0},
    {3'd5, 2'b00, 3'd5, 1'b0, 2'b00, 1'b1, 3'd1},
    {3'd6, 2'b11, 3'd6, 1'b0, 2'b11, 1'b1, 3'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] sel, input logic [1:0] m);
    @(negedge clk);
    sleepReq = 1'b1; modeSel = sel; brkMatch = m;
    @(negedge clk);
    sleepReq = 1'b0; brkMatch = 2'b00;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeUp = 1'b1;
    @(negedge clk); wakeUp = 1'b0;
  endtask

  task automatic ackAll();
    @(negedge clk); brkAck = 1'b1; flagClr = 2'b11;
    @(negedge clk); brkAck = 1'b0; flagClr = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset mode", curMode, 0);
    check("R1 reset irq", brkIrq, 0);
    check("R1 reset flags", condFlag, 0);
    rstN = 1'b1;

    // vector walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      settleCount = 16'd3;
      request(v[14:12], v[11:10]);
      repeat (8) @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R7 vec%0d mode", i), curMode, int'(v[9:7]));
      check($sformatf("R4/R5/R6/R7 vec%0d irq", i), brkIrq, int'(v[6]));
      check($sformatf("R7 vec%0d flags", i), condFlag, int'(v[5:4]));
      ackAll();
      check($sformatf("R8 vec%0d irq after ack", i), brkIrq, 0);
      check($sformatf("R8 vec%0d flags after clear", i), condFlag, 0);
      if (v[3]) begin
        pulseWake();
        repeat (8) @(negedge clk);
        check($sformatf("R9 vec%0d wake mode", i), curMode, int'(v[2:0]));
      end
    end

    // R5 timing: medium -> sub-active, armed
    request(3'd2, 2'b01);
    check("R5 mode at accept edge", curMode, 2);
    check("R5 irq not yet", brkIrq, 0);
    @(negedge clk);
    check("R5 irq one edge later", brkIrq, 1);
    ackAll();

    // R6 timing: sub-active -> high, N=5, armed
    settleCount = 16'd5;
    request(3'd0, 2'b10);
    repeat (5) @(negedge clk);
    check("R6 still sub-active at edge N", curMode, 2);
    @(negedge clk);
    check("R6 high at edge N+1", curMode, 0);
    check("R6 irq not yet at N+1", brkIrq, 0);
    @(negedge clk);
    check("R6 irq at edge N+2", brkIrq, 1);
    repeat (3) @(negedge clk);
    check("R8 irq held without ack", brkIrq, 1);
    ackAll();
    check("R8 irq cleared by ack", brkIrq, 0);

    // R7/R8/R9/R10: standby with both channels, partial clear, timed wake
    settleCount = 16'd4;
    request(3'd5, 2'b11);
    check("R7 standby entered", curMode, 5);
    check("R7 both flags", condFlag, 3);
    request(3'd3, 2'b01);
    @(negedge clk);
    check("R10 request ignored in standby", curMode, 5);
    check("R10 no irq in standby", brkIrq, 0);
    @(negedge clk); flagClr = 2'b01;
    @(negedge clk); flagClr = 2'b00;
    check("R8 clear bit0 only", condFlag, 2);
    pulseWake();
    repeat (4) @(negedge clk);
    check("R9 still standby at edge N", curMode, 5);
    @(negedge clk);
    check("R9 high at edge N+1", curMode, 0);
    check("R8 flag B kept", condFlag, 2);

    // R10: request during settling is ignored
    request(3'd2, 2'b00);
    settleCount = 16'd6;
    request(3'd1, 2'b00);
    request(3'd5, 2'b00);
    repeat (10) @(negedge clk);
    check("R10 request during settle ignored", curMode, 1);

    // R1: reset mid-operation
    brkAck = 1'b0;
    request(3'd2, 2'b01);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mode after reset", curMode, 0);
    check("R1 irq after reset", brkIrq, 0);
    check("R1 flags after reset", condFlag, 0);
    rstN = 1'b1;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule